// File: doc/BRIEF.md
# Ticket-based FIFO lock arbiter

This block arbitrates a single shared lock among N requesters and serves them strictly in the order they asked. It keeps two counters: a dispenser that hands out the next ticket number and a serving counter that names the ticket currently allowed in. A requester that pulses its acquire line is given the dispenser's present value as its ticket, and the dispenser moves on by one in the same clock. The requester then waits until its ticket matches the serving counter, at which point its grant line goes high. When it is done it pulses its release line, the serving counter steps forward and the next ticket in line is granted.

Because tickets are handed out in arrival order and served one by one, no requester can be overtaken indefinitely: a waiter sees at most N-1 others served before it. Acquires that land in the same cycle are ordered by ascending requester index. Both counters wrap modulo 2^W, where W is one bit wider than needed to index N requesters, so the match test stays exact across the wrap.

Top module: `ticket_lock`

## Requirements
- R1: After reset both counters are zero and no grant is asserted; the first acquire on an idle lock receives ticket 0.
- R2: An acquire pulse on an idle lock raises that requester's grant in the clock cycle after the pulse.
- R3: Acquire pulses arriving in the same cycle receive consecutive tickets in ascending requester index order, so the lowest index among them is served first.
- R4: A requester's grant is high exactly while it holds a ticket equal to the serving counter; at most one grant is high in any cycle.
- R5: A release pulse from the granted requester advances the serving counter by one and drops its grant in the next cycle; the next ticket holder, if any, is granted in that same cycle.
- R6: A release pulse from any requester that is not currently granted is ignored: grants and the serving counter are unchanged.
- R7: An acquire pulse from a requester that already holds a ticket or the lock is ignored: its ticket and its place in line stay as they were, and no ticket is consumed.
- R8: Across cycles grants follow strict arrival order, and ordering remains correct after both counters wrap modulo 2^W.
- R9: A waiting requester's ticket is never more than N-1 positions ahead of the serving counter, so at most N-1 others are served before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acq | input | N | Per-requester acquire pulse, bit i for requester i |
| rel | input | N | Per-requester release pulse, bit i for requester i |
| grant | output | N | Per-requester lock grant, at most one bit high |

## Verification
The bench builds the block with N = 4, which makes the counters 3 bits wide so they wrap after every eight tickets and a long random run crosses the wrap hundreds of times. With four requesters a full-width simultaneous acquire exercises the in-cycle index ordering, and every requester can be made to wait behind the maximum of three others. Directed phases cover stray releases and repeated acquires from requesters already in line.

// File: rtl/ticket_lock.sv
module ticket_lock #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] acq,
  input  logic [N-1:0] rel,
  output logic [N-1:0] grant
);

  localparam int W = $clog2(N) + 1;

  logic [W-1:0] next_tkt;
  logic [W-1:0] serving;
  logic [N-1:0] held;
  logic [W-1:0] tkt [N];

  logic [N-1:0] take;
  logic [W-1:0] offer [N];
  logic [W-1:0] taken;
  logic         rel_ok;

  assign take = acq & ~held;

  always_comb begin
    logic [W-1:0] off;
    off = '0;
    for (int i = 0; i < N; i++) begin
      offer[i] = next_tkt + off;
      off = off + W'(take[i]);
    end
    taken = off;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : gen_grant
      assign grant[g] = held[g] && (tkt[g] == serving);
    end
  endgenerate

  assign rel_ok = |(rel & grant);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_tkt <= '0;
      serving  <= '0;
      held     <= '0;
      for (int i = 0; i < N; i++) tkt[i] <= '0;
    end else begin
      next_tkt <= next_tkt + taken;
      if (rel_ok) serving <= serving + 1'b1;
      for (int i = 0; i < N; i++) begin
        if (take[i]) begin
          held[i] <= 1'b1;
          tkt[i]  <= offer[i];
        end else if (rel[i] && grant[i]) begin
          held[i] <= 1'b0;
        end
      end
    end
  end

  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r5_release_advances: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok |=> serving == $past(serving) + 1'b1);

  a_r6_stray_release: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_ok |=> $stable(serving));

  a_r1_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (next_tkt - serving) == W'($countones(held)));

  generate
    for (g = 0; g < N; g++) begin : gen_chk
      a_r7_no_retake: assert property (@(posedge clk) disable iff (!rst_n)
        (acq[g] && held[g]) |=> $stable(tkt[g]));
      a_r9_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
        held[g] |-> (W'(tkt[g] - serving) < W'(N)));
    end
  endgenerate

endmodule

// File: tb/ticket_lock_tb.sv
`timescale 1ns/1ps
module ticket_lock_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] acq = '0;
  logic [N-1:0] rel = '0;
  logic [N-1:0] grant;

  int vectors = 0;
  int errors  = 0;
  int q[$];

  always #2.5 clk = ~clk;

  ticket_lock #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .acq(acq), .rel(rel), .grant(grant)
  );

  function automatic logic [N-1:0] expect_grant();
    if (q.size() == 0) return '0;
    return N'(1) << q[0];
  endfunction

  function automatic bit in_line(int idx);
    foreach (q[k]) if (q[k] == idx) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int holder();
    return (q.size() == 0) ? -1 : q[0];
  endfunction

  task automatic step(input logic [N-1:0] a, input logic [N-1:0] r, input string tag);
    logic [N-1:0] e;
    bit pushme [N];
    e = expect_grant();
    vectors++;
    if (grant !== e) begin
      errors++;
      $display("FAIL %s grant=%b expected=%b", tag, grant, e);
    end
    for (int i = 0; i < N; i++) pushme[i] = a[i] && !in_line(i);
    if (q.size() > 0 && r[q[0]]) void'(q.pop_front());
    for (int i = 0; i < N; i++) if (pushme[i]) q.push_back(i);
    acq = a;
    rel = r;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (grant !== '0) begin
      errors++;
      $display("FAIL R1 reset grant=%b expected=%b", grant, {N{1'b0}});
    end
    rst_n = 1'b1;
    step('0, '0, "R1");
    step('0, '0, "R1");

    step(4'b0100, '0, "R2");
    step('0, '0, "R2");
    step('0, '0, "R2");
    step('0, 4'b0100, "R5");
    step('0, '0, "R5");

    step(4'b1111, '0, "R3");
    step('0, '0, "R3");
    step('0, 4'b1110, "R6");
    step('0, 4'b0001, "R5");
    step('0, 4'b0001, "R6");
    step(4'b1111, 4'b0010, "R7");
    step('0, '0, "R7");
    step('0, 4'b0100, "R5");
    step('0, 4'b1000, "R3");
    step('0, 4'b0010, "R9");
    step('0, 4'b0001, "R9");
    step('0, '0, "R8");

    step(4'b1000, '0, "R8");
    step(4'b0001, '0, "R8");
    step(4'b0010, '0, "R8");
    step('0, 4'b1000, "R8");
    step('0, 4'b0001, "R8");
    step('0, 4'b0010, "R8");
    step('0, '0, "R8");

    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] a, r;
      int h;
      a = N'($urandom) & N'($urandom);
      r = '0;
      h = holder();
      if (h >= 0 && ($urandom % 3) == 0) r[h] = 1'b1;
      if (($urandom % 5) == 0) r[$urandom % N] = 1'b1;
      step(a, r, "R4 R8");
    end

    for (int c = 0; c < 8; c++) step('0, N'(1) << (holder() < 0 ? 0 : holder()), "R5");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule